// File: doc/BRIEF.md
# I2C Segment Buffer with Stuck-Bus Rescue

This block joins two I2C segments: an upstream side facing the bus master and a downstream side facing the slaves. While the two sides are joined, a low pulled on SCL or SDA on either side is passed to the same line on the other side. The block can therefore carry normal transfers, and slave clock stretching, across the buffer. Each line keeps a note of which side first pulled it low, so a low that the block itself forwards is never reflected back to the side it came from.

A watchdog counts how long each downstream line stays low. When either line has been low without a break for a configured number of clock cycles, the block cuts the two sides apart and releases both upstream lines. It then drives a burst of sixteen clock pulses onto downstream SCL, with a configurable half-period, so that a slave frozen mid-byte can shift out its pending bits and let go of SDA. The sides are joined again only once both downstream lines and both upstream lines are high. If the downstream bus is still held after the burst, a fault flag is raised and another burst follows after a further timeout.

Top module: `i2c_seg_rescue`

## Requirements
- R1: After reset, `linked` is 1, `rescuing` and `fault` are 0, and all four drive enables are 0.
- R2: While linked, a low pulled by the master on upstream SCL or SDA is driven onto the matching downstream line (enable 1) within two cycles and released within two cycles of the master letting go; the upstream enable of that line stays 0.
- R3: While linked, a low pulled by a slave on downstream SCL or SDA (clock stretching included) is driven onto the matching upstream line, held until the slave releases even if the master pulls and lets go meanwhile, and the downstream enable of that line stays 0.
- R4: A downstream line low for fewer cycles than `cfg_timeout` leaves the block linked; any high cycle restarts that line's count.
- R5: When either downstream line has been low for `cfg_timeout` consecutive cycles (0 is taken as 1), the block drops `linked`, raises `rescuing`, and drives no upstream line.
- R6: While not linked, upstream lows are not passed downstream: downstream SDA enable stays 0 and downstream SCL is driven only by the rescue burst.
- R7: A rescue burst is exactly 16 pulses on downstream SCL, each driven low for `cfg_half` cycles and released for `cfg_half` cycles (0 is taken as 1); SCL is released when the burst ends.
- R8: After a burst, the block joins the sides again only in a cycle where all four bus lines are high; joining clears `fault`.
- R9: If either downstream line is low when a burst ends, `fault` is set, the block stays apart, and a new burst starts after another `cfg_timeout` low cycles.
- R10: The block never drives the same line low on both sides at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| up_scl_i | input | 1 | Upstream SCL level |
| up_sda_i | input | 1 | Upstream SDA level |
| up_scl_oe | output | 1 | 1 pulls upstream SCL low |
| up_sda_oe | output | 1 | 1 pulls upstream SDA low |
| dn_scl_i | input | 1 | Downstream SCL level |
| dn_sda_i | input | 1 | Downstream SDA level |
| dn_scl_oe | output | 1 | 1 pulls downstream SCL low |
| dn_sda_oe | output | 1 | 1 pulls downstream SDA low |
| cfg_timeout | input | TIMEOUT_W | Low cycles that mark a stuck line |
| cfg_half | input | HALF_W | Rescue pulse half-period in cycles |
| linked | output | 1 | Sides are joined |
| rescuing | output | 1 | Rescue burst in progress |
| fault | output | 1 | Last burst left the bus held |

## Verification
On every cycle the assertions check the structural promises: no line is driven on both sides, upstream is released and downstream SDA untouched while apart, SCL is released as a burst ends, joining happens only with all four lines high, and a fault never coexists with a joined bus. What only the directed scenarios can show is timing and counting: forwarding latency in each direction, the stretch hold, the exact timeout threshold and its restart, the pulse count and half-period, and the retry after a fault followed by recovery.

// File: rtl/i2c_seg_pkg.sv
package i2c_seg_pkg;

    typedef enum logic [1:0] {
        ST_LINK       = 2'd0,
        ST_BURST      = 2'd1,
        ST_WAIT_IDLE  = 2'd2,
        ST_FAULT_WAIT = 2'd3
    } seg_state_t;

    typedef enum logic [1:0] {
        ORG_NONE = 2'd0,
        ORG_UP   = 2'd1,
        ORG_DN   = 2'd2
    } origin_t;

    localparam int NUM_LINES = 2;
    localparam int LINE_SCL  = 0;
    localparam int LINE_SDA  = 1;

    typedef struct packed {
        logic sda;
        logic scl;
    } bus_pair_t;

endpackage

// File: rtl/i2c_seg_line.sv
module i2c_seg_line
    import i2c_seg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic up_i,
    input  logic dn_i,
    output logic up_oe,
    output logic dn_oe
);

    origin_t origin;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            origin <= ORG_NONE;
        end else begin
            case (origin)
                ORG_NONE: begin
                    if (!up_i)      origin <= ORG_UP;
                    else if (!dn_i) origin <= ORG_DN;
                end
                ORG_UP:  if (up_i) origin <= ORG_NONE;
                ORG_DN:  if (dn_i) origin <= ORG_NONE;
                default: origin <= ORG_NONE;
            endcase
        end
    end

    assign dn_oe = (origin == ORG_UP);
    assign up_oe = (origin == ORG_DN);

endmodule

// File: rtl/i2c_seg_stuck.sv
module i2c_seg_stuck
    import i2c_seg_pkg::*;
#(
    parameter int TIMEOUT_W = 24
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  bus_pair_t            lines,
    input  logic [TIMEOUT_W-1:0] limit,
    output logic                 stuck
);

    logic [TIMEOUT_W-1:0] limit_eff;
    logic [NUM_LINES-1:0] hit;
    logic [NUM_LINES-1:0] level;

    assign limit_eff = (limit == '0) ? TIMEOUT_W'(1) : limit;
    assign level     = {lines.sda, lines.scl};

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic [TIMEOUT_W-1:0] low_cnt;

        always_ff @(posedge clk) begin
            if (rst || !en || level[g]) begin
                low_cnt <= '0;
            end else if (low_cnt < limit_eff) begin
                low_cnt <= low_cnt + 1'b1;
            end
        end

        assign hit[g] = en && (low_cnt >= limit_eff);
    end

    assign stuck = |hit;

endmodule

// File: rtl/i2c_seg_pulser.sv
module i2c_seg_pulser #(
    parameter int HALF_W     = 12,
    parameter int NUM_PULSES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [HALF_W-1:0] half,
    output logic              drive_low,
    output logic              busy,
    output logic              done
);

    localparam int NW = (NUM_PULSES > 1) ? $clog2(NUM_PULSES) : 1;
    localparam logic [NW-1:0] LAST = NW'(NUM_PULSES - 1);

    logic [HALF_W-1:0] half_eff;
    logic [HALF_W-1:0] ph_cnt;
    logic [NW-1:0]     pulse_n;
    logic              low_ph;
    logic              ph_end;

    assign half_eff = (half == '0) ? HALF_W'(1) : half;
    assign ph_end   = (ph_cnt == half_eff - 1'b1);
    assign done     = busy && ph_end && !low_ph && (pulse_n == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            low_ph  <= 1'b0;
            ph_cnt  <= '0;
            pulse_n <= '0;
        end else if (start) begin
            busy    <= 1'b1;
            low_ph  <= 1'b1;
            ph_cnt  <= '0;
            pulse_n <= '0;
        end else if (busy) begin
            if (ph_end) begin
                ph_cnt <= '0;
                if (low_ph) begin
                    low_ph <= 1'b0;
                end else if (pulse_n == LAST) begin
                    busy <= 1'b0;
                end else begin
                    pulse_n <= pulse_n + 1'b1;
                    low_ph  <= 1'b1;
                end
            end else begin
                ph_cnt <= ph_cnt + 1'b1;
            end
        end
    end

    assign drive_low = busy && low_ph;

endmodule

// File: rtl/i2c_seg_rescue.sv
module i2c_seg_rescue
    import i2c_seg_pkg::*;
#(
    parameter int TIMEOUT_W  = 24,
    parameter int HALF_W     = 12,
    parameter int NUM_PULSES = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 up_scl_i,
    input  logic                 up_sda_i,
    output logic                 up_scl_oe,
    output logic                 up_sda_oe,
    input  logic                 dn_scl_i,
    input  logic                 dn_sda_i,
    output logic                 dn_scl_oe,
    output logic                 dn_sda_oe,
    input  logic [TIMEOUT_W-1:0] cfg_timeout,
    input  logic [HALF_W-1:0]    cfg_half,
    output logic                 linked,
    output logic                 rescuing,
    output logic                 fault
);

    seg_state_t state, state_nx;
    bus_pair_t  up_lvl, dn_lvl, f_up_oe, f_dn_oe;
    logic       stuck, pg_start, pg_low, pg_busy, pg_done;
    logic       set_fault, clr_fault, dn_idle, up_idle;

    assign up_lvl  = '{sda: up_sda_i, scl: up_scl_i};
    assign dn_lvl  = '{sda: dn_sda_i, scl: dn_scl_i};
    assign dn_idle = dn_lvl.scl && dn_lvl.sda;
    assign up_idle = up_lvl.scl && up_lvl.sda;

    i2c_seg_line u_fwd_scl (
        .clk  (clk),
        .rst  (rst),
        .en   (linked),
        .up_i (up_lvl.scl),
        .dn_i (dn_lvl.scl),
        .up_oe(f_up_oe.scl),
        .dn_oe(f_dn_oe.scl)
    );

    i2c_seg_line u_fwd_sda (
        .clk  (clk),
        .rst  (rst),
        .en   (linked),
        .up_i (up_lvl.sda),
        .dn_i (dn_lvl.sda),
        .up_oe(f_up_oe.sda),
        .dn_oe(f_dn_oe.sda)
    );

    i2c_seg_stuck #(.TIMEOUT_W(TIMEOUT_W)) u_stuck (
        .clk  (clk),
        .rst  (rst),
        .en   (state != ST_BURST),
        .lines(dn_lvl),
        .limit(cfg_timeout),
        .stuck(stuck)
    );

    i2c_seg_pulser #(.HALF_W(HALF_W), .NUM_PULSES(NUM_PULSES)) u_pulser (
        .clk      (clk),
        .rst      (rst),
        .start    (pg_start),
        .half     (cfg_half),
        .drive_low(pg_low),
        .busy     (pg_busy),
        .done     (pg_done)
    );

    always_comb begin
        state_nx  = state;
        pg_start  = 1'b0;
        set_fault = 1'b0;
        clr_fault = 1'b0;
        case (state)
            ST_LINK: begin
                if (stuck) begin
                    state_nx = ST_BURST;
                    pg_start = 1'b1;
                end
            end
            ST_BURST: begin
                if (pg_done) begin
                    if (dn_idle) begin
                        state_nx = ST_WAIT_IDLE;
                    end else begin
                        state_nx  = ST_FAULT_WAIT;
                        set_fault = 1'b1;
                    end
                end
            end
            ST_WAIT_IDLE: begin
                if (stuck) begin
                    state_nx = ST_BURST;
                    pg_start = 1'b1;
                end else if (dn_idle && up_idle) begin
                    state_nx  = ST_LINK;
                    clr_fault = 1'b1;
                end
            end
            ST_FAULT_WAIT: begin
                if (stuck) begin
                    state_nx = ST_BURST;
                    pg_start = 1'b1;
                end else if (dn_idle) begin
                    state_nx = ST_WAIT_IDLE;
                end
            end
            default: state_nx = ST_LINK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_LINK;
            fault <= 1'b0;
        end else begin
            state <= state_nx;
            if (set_fault)      fault <= 1'b1;
            else if (clr_fault) fault <= 1'b0;
        end
    end

    assign linked    = (state == ST_LINK);
    assign rescuing  = (state == ST_BURST);
    assign up_scl_oe = linked && f_up_oe.scl;
    assign up_sda_oe = linked && f_up_oe.sda;
    assign dn_scl_oe = linked ? f_dn_oe.scl : (pg_busy && pg_low);
    assign dn_sda_oe = linked && f_dn_oe.sda;

endmodule

// File: rtl/i2c_seg_rescue_chk.sv
module i2c_seg_rescue_chk (
    input logic clk,
    input logic rst,
    input logic up_scl_i,
    input logic up_sda_i,
    input logic dn_scl_i,
    input logic dn_sda_i,
    input logic up_scl_oe,
    input logic up_sda_oe,
    input logic dn_scl_oe,
    input logic dn_sda_oe,
    input logic linked,
    input logic rescuing,
    input logic fault
);

    a_r1_modes_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(linked && rescuing));

    a_r5_up_released: assert property (@(posedge clk) disable iff (rst)
        !linked |-> (!up_scl_oe && !up_sda_oe));

    a_r6_sda_isolated: assert property (@(posedge clk) disable iff (rst)
        !linked |-> !dn_sda_oe);

    a_r7_scl_freed: assert property (@(posedge clk) disable iff (rst)
        $fell(rescuing) |-> !dn_scl_oe);

    a_r8_join_idle: assert property (@(posedge clk) disable iff (rst)
        $rose(linked) |-> $past(up_scl_i && up_sda_i && dn_scl_i && dn_sda_i));

    a_r9_fault_apart: assert property (@(posedge clk) disable iff (rst)
        fault |-> !linked);

    a_r10_scl_one_side: assert property (@(posedge clk) disable iff (rst)
        !(up_scl_oe && dn_scl_oe));

    a_r10_sda_one_side: assert property (@(posedge clk) disable iff (rst)
        !(up_sda_oe && dn_sda_oe));

endmodule

bind i2c_seg_rescue i2c_seg_rescue_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .up_scl_i (up_scl_i),
    .up_sda_i (up_sda_i),
    .dn_scl_i (dn_scl_i),
    .dn_sda_i (dn_sda_i),
    .up_scl_oe(up_scl_oe),
    .up_sda_oe(up_sda_oe),
    .dn_scl_oe(dn_scl_oe),
    .dn_sda_oe(dn_sda_oe),
    .linked   (linked),
    .rescuing (rescuing),
    .fault    (fault)
);

// File: tb/sim_i2c_seg_rescue.sv
`timescale 1ns/1ps
module sim_i2c_seg_rescue;

    localparam int TW   = 24;
    localparam int HW   = 12;
    localparam int TMO  = 200;
    localparam int HALF = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic m_scl = 0, m_sda = 0, s_scl = 0, s_sda = 0;
    int   s_rel = 0, s_cnt = 0;
    logic up_scl_oe, up_sda_oe, dn_scl_oe, dn_sda_oe;
    logic linked, rescuing, fault;
    logic up_scl, up_sda, dn_scl, dn_sda;

    assign up_scl = ~(up_scl_oe | m_scl);
    assign up_sda = ~(up_sda_oe | m_sda);
    assign dn_scl = ~(dn_scl_oe | s_scl);
    assign dn_sda = ~(dn_sda_oe | s_sda);

    i2c_seg_rescue #(.TIMEOUT_W(TW), .HALF_W(HW), .NUM_PULSES(16)) u0 (
        .clk(clk), .rst(rst),
        .up_scl_i(up_scl), .up_sda_i(up_sda),
        .up_scl_oe(up_scl_oe), .up_sda_oe(up_sda_oe),
        .dn_scl_i(dn_scl), .dn_sda_i(dn_sda),
        .dn_scl_oe(dn_scl_oe), .dn_sda_oe(dn_sda_oe),
        .cfg_timeout(TW'(TMO)), .cfg_half(HW'(HALF)),
        .linked(linked), .rescuing(rescuing), .fault(fault)
    );

    int checks = 0, fails = 0;
    int pulses = 0, bad_runs = 0, run = 0;
    logic prev_oe = 0;

    // slave frozen mid-byte: lets SDA go after s_rel falling SCL edges
    always @(negedge dn_scl) begin
        if (s_sda && s_rel != 0) begin
            s_cnt = s_cnt + 1;
            if (s_cnt >= s_rel) s_sda = 0;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (dn_scl_oe && !prev_oe) pulses = pulses + 1;
            if (dn_scl_oe) run = run + 1;
            else if (prev_oe) begin
                if (rescuing && run != HALF) bad_runs = bad_runs + 1;
                run = 0;
            end
            prev_oe = dn_scl_oe;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_for(input logic want_rescue, input int limit, output int took);
        took = 0;
        while (rescuing != want_rescue && took < limit) begin
            @(negedge clk);
            took++;
        end
    endtask

    task automatic t_reset;
        check("R1 linked", linked, 1);
        check("R1 rescuing", rescuing, 0);
        check("R1 fault", fault, 0);
        check("R1 enables", {up_scl_oe, up_sda_oe, dn_scl_oe, dn_sda_oe}, 0);
    endtask

    task automatic t_down_fwd;
        m_sda = 1; cyc(2);
        check("R2 sda forwarded", dn_sda_oe, 1);
        check("R2 sda no echo", up_sda_oe, 0);
        m_scl = 1; cyc(2);
        check("R2 scl forwarded", dn_scl_oe, 1);
        check("R2 scl no echo", up_scl_oe, 0);
        m_scl = 0; m_sda = 0; cyc(2);
        check("R2 released", {dn_scl_oe, dn_sda_oe}, 0);
    endtask

    task automatic t_up_fwd;
        s_scl = 1; cyc(2);
        check("R3 stretch forwarded", up_scl_oe, 1);
        check("R3 no echo", dn_scl_oe, 0);
        m_scl = 1; cyc(3); m_scl = 0; cyc(2);
        check("R3 stretch held", up_scl, 0);
        s_scl = 0; cyc(2);
        check("R3 stretch released", {up_scl_oe, up_scl}, 1);
        s_sda = 1; cyc(2);
        check("R3 sda forwarded", up_sda_oe, 1);
        s_sda = 0; cyc(2);
        check("R3 sda released", up_sda_oe, 0);
    endtask

    task automatic t_short_low;
        s_sda = 1; cyc(TMO - 3); s_sda = 0; cyc(1);
        s_sda = 1; cyc(TMO - 3); s_sda = 0; cyc(3);
        check("R4 still linked", linked, 1);
        check("R4 no rescue", rescuing, 0);
    endtask

    task automatic t_rescue;
        int took, base;
        base = pulses; bad_runs = 0;
        s_cnt = 0; s_rel = 9; s_sda = 1;
        wait_for(1'b1, TMO + 20, took);
        check("R5 rescue started", rescuing, 1);
        check("R5 not before timeout", int'(took >= TMO - 1), 1);
        check("R5 linked dropped", linked, 0);
        check("R5 upstream free", {up_scl, up_sda}, 2'b11);
        m_sda = 1; cyc(6);
        check("R6 sda not passed", dn_sda_oe, 0);
        m_sda = 0;
        wait_for(1'b0, 1000, took);
        cyc(3);
        check("R7 pulse count", pulses - base, 16);
        check("R7 half period", bad_runs, 0);
        check("R7 scl released", dn_scl_oe, 0);
        check("R8 rejoined", linked, 1);
        check("R8 no fault", fault, 0);
    endtask

    task automatic t_wait_master;
        int took;
        s_cnt = 0; s_rel = 9; s_sda = 1;
        wait_for(1'b1, TMO + 20, took);
        m_scl = 1;
        wait_for(1'b0, 1000, took);
        cyc(20);
        check("R8 waits for upstream idle", linked, 0);
        check("R6 scl not passed", dn_scl_oe, 0);
        m_scl = 0; cyc(3);
        check("R8 joins when idle", linked, 1);
    endtask

    task automatic t_fault;
        int took, base;
        base = pulses;
        s_cnt = 0; s_rel = 0; s_sda = 1;
        wait_for(1'b1, TMO + 20, took);
        wait_for(1'b0, 1000, took);
        cyc(2);
        check("R9 fault set", fault, 1);
        check("R9 stays apart", linked, 0);
        wait_for(1'b1, TMO + 20, took);
        check("R9 retry burst", rescuing, 1);
        s_sda = 0;
        wait_for(1'b0, 1000, took);
        cyc(3);
        check("R9 total pulses", pulses - base, 32);
        check("R8 fault cleared", fault, 0);
        check("R8 rejoined after fault", linked, 1);
    endtask

    initial begin
        cyc(4); rst = 0; cyc(2);
        t_reset();
        t_down_fwd();
        t_up_fwd();
        t_short_low();
        t_rescue();
        cyc(5);
        t_wait_master();
        cyc(5);
        t_fault();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule